// File: doc/BRIEF.md
# Keyed-Refresh Watchdog Timer

This block is a 16-bit down-counter with a byte-wide write bus. It has two modes. In timer mode it is an ordinary programmable counter. Software loads a preset through a high byte and a low byte register. A control register then starts or stops the count, picks one-shot or free-running operation, and picks the internal clock or an external event as the count source. A CPU halt indication freezes the count in this mode.

Software moves the block into watchdog mode by clearing an active-low bit in the control register. From that point the counter decrements on every clock. The run, one-shot, source-select and halt inputs no longer have any effect, and software cannot leave the mode. To keep the system alive, software writes the byte AAh and then the byte 55h to the low register. This reloads the preset.

If the counter reaches zero and takes one more tick, the block drives a registered system reset pulse. When the pulse ends, all of its own state returns to its reset values.

Top module: `kwdt_top`

## Requirements
- R1: Register map on `bus_addr_i`: 0 is the preset high byte, 1 is the preset low byte, and 2 is control. In timer mode, a write to the low register loads the counter at once with {high byte, written byte}. That write is never treated as a key byte. A write to the high register only stores the byte.
- R2: Control bits: bit 0 is run, bit 1 is one-shot, bits 3:2 are the source select (00 counts every clock, any other value counts only on cycles with `ext_evt_i` high), and bit 7 is the active-low watchdog enable. In timer mode the counter decrements once per tick while run is 1 and `halt_i` is 0. At a tick with the count at zero, free-running operation reloads the preset. One-shot operation holds zero and clears run.
- R3: Writing control with bit 7 equal to 0 in timer mode enters watchdog mode. At the same edge, `wd_mode_o` rises and the counter loads the preset.
- R4: In watchdog mode the counter decrements on every clock. The run bit, the one-shot bit, the source select, `ext_evt_i` and `halt_i` have no effect.
- R5: In watchdog mode, a write of AAh to the low register followed directly by a write of 55h to the low register reloads the preset at the 55h write.
- R6: Any other low-register write between the AAh and the 55h cancels the sequence. A write of AAh always starts a new sequence. Writes to the high or control register do not affect the sequence.
- R7: In watchdog mode the preset is locked. High-register writes are ignored, and low-register writes never load the counter.
- R8: Once in watchdog mode, no register write returns the block to timer mode.
- R9: A watchdog-mode tick with the count at zero raises `sys_rst_o` on the next cycle, for RST_LEN (default 4) cycles. A valid key completed on that same edge reloads the counter instead, and no reset follows.
- R10: Bus writes are ignored while `sys_rst_o` is high. When the pulse ends, the count, the preset, the control bits, the key sequence and the mode all return to their reset values.
- R11: After `rst_n` the count is 0, `wd_mode_o` is 0 and `sys_rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| halt_i | input | 1 | CPU halt indication |
| ext_evt_i | input | 1 | External count event (timer mode only) |
| count_o | output | 16 | Current counter value |
| wd_mode_o | output | 1 | High while watchdog mode is armed |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Several behaviours are checked by assertions on every cycle:
- In watchdog mode the counter steps down by exactly one each clock.
- The preset and the mode stay locked once armed.
- A zero count with no key always leads to the reset pulse.
- The pulse ends with the block back in its reset state.
- The key state can only become pending after an AAh write.

Only the bench scenarios can show the rest. This covers the key ordering over mixed streams of writes and what the counter does in timer mode. It also covers the race where a key completes as the count expires, and the fact that writes made during the pulse leave no trace.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_HI   = 2'd0;
    localparam logic [ADDR_W-1:0] A_LO   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

    localparam logic [BUS_W-1:0] KEY_OPEN  = 8'hAA;
    localparam logic [BUS_W-1:0] KEY_CLOSE = 8'h55;

    localparam int C_RUN     = 0;
    localparam int C_ONESHOT = 1;
    localparam int C_SEL_LSB = 2;
    localparam int C_WDOFF_N = 7;

    typedef enum logic {
        KEY_WAIT_OPEN,
        KEY_HAVE_OPEN
    } key_st_e;
endpackage

// File: rtl/kwdt_regs.sv
`timescale 1ns/1ps
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_clr,
    input  logic                hold,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    input  logic                stop_req,
    output logic [CNT_W-1:0]    preset,
    output logic                armed,
    output logic                run,
    output logic                oneshot,
    output logic [1:0]          src_sel,
    output logic                load_req,
    output logic [CNT_W-1:0]    load_val
);
    localparam int HI_W = CNT_W - BUS_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [BUS_W-1:0] lo;
        logic             run;
        logic             oneshot;
        logic [1:0]       src_sel;
        logic             armed;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d   = regs_q;
        load_req = 1'b0;
        load_val = {regs_q.hi, regs_q.lo};
        if (soft_clr) begin
            regs_d = '0;
        end else if (!hold) begin
            if (stop_req) begin
                regs_d.run = 1'b0;
            end
            if (wr_en) begin
                case (addr)
                    A_HI: begin
                        if (!regs_q.armed) begin
                            regs_d.hi = wdata[HI_W-1:0];
                        end
                    end
                    A_LO: begin
                        if (!regs_q.armed) begin
                            regs_d.lo = wdata;
                            load_req  = 1'b1;
                            load_val  = {regs_q.hi, wdata};
                        end
                    end
                    A_CTRL: begin
                        regs_d.run     = wdata[C_RUN];
                        regs_d.oneshot = wdata[C_ONESHOT];
                        regs_d.src_sel = wdata[C_SEL_LSB +: 2];
                        if (!regs_q.armed && !wdata[C_WDOFF_N]) begin
                            regs_d.armed = 1'b1;
                            load_req     = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign preset  = {regs_q.hi, regs_q.lo};
    assign armed   = regs_q.armed;
    assign run     = regs_q.run;
    assign oneshot = regs_q.oneshot;
    assign src_sel = regs_q.src_sel;

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !soft_clr |=> armed); // R8
    AST_PRESET_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !soft_clr |=> $stable(preset)); // R7
endmodule

// File: rtl/kwdt_key.sv
`timescale 1ns/1ps
module kwdt_key
    import kwdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr,
    input  logic               hold,
    input  logic               armed,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BUS_W-1:0]   wdata,
    output logic               reload
);
    typedef struct packed {
        key_st_e st;
    } key_t;

    key_t key_d, key_q;
    logic lo_key_wr;

    always_comb begin
        key_d     = key_q;
        reload    = 1'b0;
        lo_key_wr = armed && !hold && wr_en && (addr == A_LO);
        if (soft_clr) begin
            key_d.st = KEY_WAIT_OPEN;
        end else if (lo_key_wr) begin
            if (wdata == KEY_OPEN) begin
                key_d.st = KEY_HAVE_OPEN;
            end else if (key_q.st == KEY_HAVE_OPEN && wdata == KEY_CLOSE) begin
                reload   = 1'b1;
                key_d.st = KEY_WAIT_OPEN;
            end else begin
                key_d.st = KEY_WAIT_OPEN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '{st: KEY_WAIT_OPEN};
        end else begin
            key_q <= key_d;
        end
    end

    AST_OPEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (key_q.st == KEY_HAVE_OPEN) && ($past(key_q.st) == KEY_WAIT_OPEN)
        |-> $past(wr_en && addr == A_LO && wdata == KEY_OPEN)); // R6
endmodule

// File: rtl/kwdt_counter.sv
`timescale 1ns/1ps
module kwdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              hold,
    input  logic              armed,
    input  logic              run,
    input  logic              oneshot,
    input  logic [1:0]        src_sel,
    input  logic              ext_evt,
    input  logic              halt,
    input  logic              load_req,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              reload,
    input  logic [CNT_W-1:0]  preset,
    output logic [CNT_W-1:0]  count,
    output logic              eoc,
    output logic              stop_req
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic tick;

    always_comb begin
        cnt_d    = cnt_q;
        eoc      = 1'b0;
        stop_req = 1'b0;
        if (armed) begin
            tick = 1'b1;
        end else begin
            tick = run && !halt && ((src_sel == 2'b00) || ext_evt);
        end
        if (soft_clr) begin
            cnt_d.cnt = '0;
        end else if (hold) begin
            cnt_d = cnt_q;
        end else if (load_req) begin
            cnt_d.cnt = load_val;
        end else if (reload) begin
            cnt_d.cnt = preset;
        end else if (tick) begin
            if (cnt_q.cnt != '0) begin
                cnt_d.cnt = cnt_q.cnt - CNT_W'(1);
            end else if (armed) begin
                eoc = 1'b1;
            end else if (oneshot) begin
                stop_req = 1'b1;
            end else begin
                cnt_d.cnt = preset;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.cnt;

    AST_WD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !hold && !soft_clr && !reload && !load_req && (count != '0)
        |=> count == $past(count) - CNT_W'(1)); // R4
endmodule

// File: rtl/kwdt_rstgen.sv
`timescale 1ns/1ps
module kwdt_rstgen #(
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc,
    output logic sys_rst,
    output logic soft_clr
);
    localparam int RST_CW = $clog2(RST_LEN) + 1;

    typedef struct packed {
        logic              active;
        logic [RST_CW-1:0] left;
    } pulse_t;

    pulse_t pulse_d, pulse_q;

    always_comb begin
        pulse_d  = pulse_q;
        soft_clr = pulse_q.active && (pulse_q.left == '0);
        if (pulse_q.active) begin
            if (pulse_q.left == '0) begin
                pulse_d.active = 1'b0;
            end else begin
                pulse_d.left = pulse_q.left - RST_CW'(1);
            end
        end else if (eoc) begin
            pulse_d.active = 1'b1;
            pulse_d.left   = RST_CW'(RST_LEN - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign sys_rst = pulse_q.active;
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    input  logic              halt_i,
    input  logic              ext_evt_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              wd_mode_o,
    output logic              sys_rst_o
);
    logic             soft_clr, hold, stop_req, armed, run, oneshot;
    logic [1:0]       src_sel;
    logic             load_req, key_reload, eoc;
    logic [CNT_W-1:0] preset, load_val, count;

    assign hold = sys_rst_o;

    kwdt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .hold(hold),
        .wr_en(bus_wr_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
        .stop_req(stop_req), .preset(preset), .armed(armed), .run(run),
        .oneshot(oneshot), .src_sel(src_sel), .load_req(load_req),
        .load_val(load_val)
    );

    kwdt_key key_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .hold(hold),
        .armed(armed), .wr_en(bus_wr_i), .addr(bus_addr_i),
        .wdata(bus_wdata_i), .reload(key_reload)
    );

    kwdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .hold(hold),
        .armed(armed), .run(run), .oneshot(oneshot), .src_sel(src_sel),
        .ext_evt(ext_evt_i), .halt(halt_i), .load_req(load_req),
        .load_val(load_val), .reload(key_reload), .preset(preset),
        .count(count), .eoc(eoc), .stop_req(stop_req)
    );

    kwdt_rstgen #(.RST_LEN(RST_LEN)) rst_i (
        .clk(clk), .rst_n(rst_n), .eoc(eoc),
        .sys_rst(sys_rst_o), .soft_clr(soft_clr)
    );

    assign count_o   = count;
    assign wd_mode_o = armed;

    AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        wd_mode_o && !sys_rst_o && (count_o == '0) && !key_reload
        |=> sys_rst_o); // R9
    AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> !wd_mode_o && (count_o == '0)); // R10
endmodule

// File: tb/kwdt_top_tb_top.sv
`timescale 1ns/1ps
module kwdt_top_tb_top;
    import kwdt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        halt = 1'b0;
    logic        ext_evt = 1'b0;
    logic [15:0] count;
    logic        wd_mode, sys_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_cnt;
    logic        m_key;
    localparam logic [15:0] WD_PRESET = 16'h0400;

    always #5 clk = ~clk;

    kwdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .halt_i(halt), .ext_evt_i(ext_evt),
        .count_o(count), .wd_mode_o(wd_mode), .sys_rst_o(sys_rst)
    );

    function automatic logic [15:0] fx_lo_count(input logic [15:0] c, input logic k,
                                                 input logic [7:0] b, input logic [15:0] p);
        if (k && b == KEY_CLOSE) return p;
        return c - 16'd1;
    endfunction

    function automatic logic fx_key(input logic [7:0] b);
        return b == KEY_OPEN;
    endfunction

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk16("R11 count", count, 16'h0000);
        chk1("R11 wd_mode", wd_mode, 1'b0);
        chk1("R11 sys_rst", sys_rst, 1'b0);

        // R1: direct preset loads in timer mode
        wr(A_HI, 8'h12); wr(A_LO, 8'h34);
        chk16("R1 load", count, 16'h1234);
        wr(A_LO, KEY_OPEN); wr(A_LO, KEY_CLOSE);
        chk16("R1 no key in timer", count, 16'h1255);

        // R2: run, halt, source select
        wr(A_CTRL, 8'h81);
        chk16("R2 start edge", count, 16'h1255);
        idle(3);
        chk16("R2 run", count, 16'h1252);
        halt = 1'b1; idle(3);
        chk16("R2 halt freezes", count, 16'h1252);
        halt = 1'b0;
        wr(A_CTRL, 8'h85);
        idle(3);
        chk16("R2 ext gated", count, 16'h1251);
        ext_evt = 1'b1; idle(2); ext_evt = 1'b0;
        chk16("R2 ext counts", count, 16'h124F);
        wr(A_CTRL, 8'h80); wr(A_HI, 8'h00);
        chk16("R1 hi write no load", count, 16'h124F);
        wr(A_LO, 8'h02);
        wr(A_CTRL, 8'h81);
        idle(3);
        chk16("R2 free-running wrap", count, 16'h0002);
        wr(A_CTRL, 8'h83);
        idle(5);
        chk16("R2 one-shot holds zero", count, 16'h0000);
        wr(A_LO, 8'h05); idle(2);
        chk16("R2 one-shot cleared run", count, 16'h0005);

        // R3/R4: arm with every override set
        wr(A_HI, 8'h04); wr(A_LO, 8'h00);
        halt = 1'b1; ext_evt = 1'b0;
        wr(A_CTRL, 8'h0E);
        chk1("R3 armed", wd_mode, 1'b1);
        chk16("R3 preset loaded", count, WD_PRESET);
        idle(10);
        chk16("R4 runs despite halt/run/select", count, WD_PRESET - 16'd10);

        // random mix: R4 R5 R6 R7 R8
        m_cnt = WD_PRESET - 16'd10; m_key = 1'b0;
        for (int it = 0; it < 48; it++) begin
            int op = $urandom_range(0, 9);
            logic [7:0] b;
            if (op <= 3) b = KEY_OPEN;
            else if (op <= 5) b = KEY_CLOSE;
            else b = 8'($urandom_range(0, 255));
            if (op <= 6) begin
                m_cnt = fx_lo_count(m_cnt, m_key, b, WD_PRESET);
                m_key = fx_key(b);
                wr(A_LO, b);
            end else if (op == 7) begin
                wr(A_HI, 8'($urandom_range(0, 255)));
                m_cnt = m_cnt - 16'd1;
            end else if (op == 8) begin
                wr(A_CTRL, 8'($urandom_range(0, 255)));
                m_cnt = m_cnt - 16'd1;
            end else begin
                int n = $urandom_range(1, 4);
                halt = 1'($urandom_range(0, 1));
                ext_evt = 1'($urandom_range(0, 1));
                idle(n);
                m_cnt = m_cnt - 16'(n);
            end
            chk16("R5 R6 R7 R4 random", count, m_cnt);
        end
        halt = 1'b0; ext_evt = 1'b0;

        wr(A_CTRL, 8'h80);
        chk1("R8 cannot disarm", wd_mode, 1'b1);

        wr(A_LO, KEY_OPEN); wr(A_LO, KEY_CLOSE);
        chk16("R5 key reload", count, WD_PRESET);
        wr(A_LO, KEY_OPEN); wr(A_LO, 8'h12); wr(A_LO, KEY_CLOSE);
        chk16("R6 broken key", count, WD_PRESET - 16'd3);
        wr(A_LO, KEY_OPEN); wr(A_LO, KEY_OPEN); wr(A_LO, KEY_CLOSE);
        chk16("R6 open restarts", count, WD_PRESET);
        wr(A_LO, KEY_OPEN); wr(A_HI, 8'h77); wr(A_LO, KEY_CLOSE);
        chk16("R6 R7 hi write between", count, WD_PRESET);
        wr(A_LO, 8'h10);
        chk16("R7 lo write no load", count, WD_PRESET - 16'd1);

        // R9/R10: expiry and pulse
        idle(int'(WD_PRESET) - 1);
        chk16("R9 at zero", count, 16'h0000);
        chk1("R9 not yet", sys_rst, 1'b0);
        idle(1);
        chk1("R9 pulse", sys_rst, 1'b1);
        wr(A_HI, 8'h55);
        idle(2);
        chk1("R9 pulse width", sys_rst, 1'b1);
        idle(1);
        chk1("R9 pulse ends", sys_rst, 1'b0);
        chk1("R10 mode cleared", wd_mode, 1'b0);
        chk16("R10 count cleared", count, 16'h0000);
        wr(A_LO, 8'h07);
        chk16("R10 write in pulse ignored", count, 16'h0007);

        // R9: key beats expiry on the same edge
        wr(A_HI, 8'h00); wr(A_LO, 8'h03);
        wr(A_CTRL, 8'h00);
        chk16("R3 rearm", count, 16'h0003);
        wr(A_LO, KEY_OPEN); idle(2);
        chk16("R9 race at zero", count, 16'h0000);
        wr(A_LO, KEY_CLOSE);
        chk16("R9 race reload", count, 16'h0003);
        chk1("R9 race no pulse", sys_rst, 1'b0);
        idle(1);
        chk1("R9 race still none", sys_rst, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule